// File: doc/BRIEF.md
# Message Builder and Frame Transmitter

This block turns a variable held in a word-wide memory into an outgoing Ethernet frame on a byte-wide transmit stream. A copy engine reads the variable's 32-bit words out of the memory and pushes them into a single message FIFO. A transmit engine runs at the same time and drives the frame out one byte per cycle. It sends the 14-byte header (destination, source, type) first and then takes the payload from the FIFO, one word for every four bytes. If the body is shorter than 46 bytes it is filled with zeros, so that the frame reaches the minimum size once the checksum is appended downstream.

A controller starts the copy engine with a base address and a word count. From the next cycle on it may start the transmit engine, without waiting for the copy to finish. The header time and the 4:1 width ratio keep the FIFO ahead of the reader, so with the default setup times the reader never finds it empty. There is only one message buffer. A second message is refused until the first has left the block. Each engine reports completion with a single-cycle pulse.

Top module: `msg_frame_pipe`

## Requirements
- R1: After reset, tx_valid, tx_last, create_done, send_done and underrun are all low, and no message is held.
- R2: A create_start is taken only when no message is held, the copy engine is idle, and create_len is between 1 and MAX_WORDS. Otherwise it has no effect: no create_done follows, and the held message and its FIFO contents are unchanged. A held message is released in the cycle of its last transmitted byte, and a new create_start is taken after that.
- R3: create_done pulses for exactly one cycle, CR_SETUP + create_len + 1 clock edges after the edge that took create_start.
- R4: A frame begins with the header bytes in order: dst_addr, then src_addr, then eth_type, each most significant byte first. The payload follows, word by word from increasing addresses, with each 32-bit word sent most significant byte first.
- R5: The body holds max(46, 4 x words) bytes. Bytes beyond the payload are 0x00, so a frame is 14 + max(46, 4 x words) bytes long. tx_last is high on the final byte only.
- R6: A send_start is taken only when a message is held and the transmit engine is idle. Otherwise it has no effect, and no byte is transmitted.
- R7: The first header byte appears SD_SETUP + 1 edges after the edge that took send_start. send_done is high for one cycle, in the cycle that carries the final byte.
- R8: When send_start follows the accepted create_start by one cycle, the frame is complete and correct with default parameters, and underrun stays low. The FIFO is read only after all 14 header bytes have been output.
- R9: If the transmit engine needs a payload word while the FIFO is empty, it outputs a 0x00 byte and sets underrun. underrun then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_we | input | 1 | Write enable of the variable memory |
| ram_waddr | input | ADDR_W | Variable memory write address |
| ram_wdata | input | WORD_W | Variable memory write data |
| create_start | input | 1 | Start copying a variable into the FIFO |
| create_base | input | ADDR_W | First word address of the variable |
| create_len | input | clog2(MAX_WORDS+1) | Variable length in words |
| send_start | input | 1 | Start transmitting the held message |
| dst_addr | input | 48 | Destination address, latched at send start |
| src_addr | input | 48 | Source address, latched at send start |
| eth_type | input | 16 | Type field, latched at send start |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | tx_data carries a frame byte |
| tx_last | output | 1 | Final byte of the frame |
| create_done | output | 1 | Copy complete pulse |
| send_done | output | 1 | Transmit complete pulse |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
Some rules are checked on every cycle by the embedded properties. The FIFO never overflows and is never popped while empty. The first pop comes only after the full header is on the stream. tx_last never appears without tx_valid, and every frame meets the minimum length. Both done signals are single pulses, and underrun never falls. Other behaviour only shows in the bench's scenarios: exact byte order and padding contents, the latencies of the two done pulses and of the first byte, and whether a refused create or send leaves the held message untouched. A second instance with a long copy setup is the only way to bring out the underrun path.

// File: rtl/mfp_pkg.sv
`timescale 1ns/1ps
package mfp_pkg;
   localparam int HDR_BYTES = 14;
   localparam int MIN_BODY  = 46;
   localparam int MAC_W     = 48;
   localparam int TYPE_W    = 16;
   localparam int HDR_W     = 2*MAC_W + TYPE_W;

   typedef enum logic [1:0] {C_IDLE, C_SETUP, C_COPY} cr_state_t;
   typedef enum logic [1:0] {S_IDLE, S_SETUP, S_HDR, S_BODY} sd_state_t;
endpackage

// File: rtl/mfp_var_ram.sv
`timescale 1ns/1ps
module mfp_var_ram #(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem [0:DEPTH-1];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/mfp_fifo.sv
`timescale 1ns/1ps
module mfp_fifo #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [WORD_W-1:0] wdata,
   input  logic              pop,
   output logic [WORD_W-1:0] rdata,
   output logic              empty,
   output logic              full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if ((1 << PW) != DEPTH) begin : g_bad_depth
         $error("mfp_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [WORD_W-1:0] mem [0:DEPTH-1];
   logic [PW-1:0]     wp, rp;
   logic [PW:0]       cnt;
   logic              do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign empty   = (cnt == '0);
   assign full    = (cnt == (PW+1)'(DEPTH));
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R2: one message at a time never exceeds the FIFO depth
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));
   // R9: the reader never pops an empty FIFO, it flags underrun instead
   assert_no_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/mfp_create.sv
`timescale 1ns/1ps
module mfp_create
   import mfp_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int WORD_W    = 32,
   parameter int MAX_WORDS = 16,
   parameter int CR_SETUP  = 8,
   parameter int LEN_W     = $clog2(MAX_WORDS+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  nwords,
   input  logic              release_msg,
   output logic [ADDR_W-1:0] ram_raddr,
   input  logic [WORD_W-1:0] ram_rdata,
   output logic              push,
   output logic [WORD_W-1:0] push_data,
   output logic              done,
   output logic              buf_full,
   output logic [LEN_W-1:0]  msg_words
);
   localparam int SW = $clog2(CR_SETUP+1);

   generate
      if (CR_SETUP < 1) begin : g_bad_setup
         $error("mfp_create: CR_SETUP must be at least 1");
      end
   endgenerate

   cr_state_t         st;
   logic [SW-1:0]     cnt;
   logic [LEN_W-1:0]  ic, wc;
   logic [ADDR_W-1:0] base_q;
   logic              rv;
   logic              accept;

   assign accept    = start && (st == C_IDLE) && !buf_full &&
                      (nwords != '0) && (nwords <= LEN_W'(MAX_WORDS));
   assign ram_raddr = base_q + ADDR_W'(ic);
   assign push      = rv;
   assign push_data = ram_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= C_IDLE;
         cnt       <= '0;
         ic        <= '0;
         wc        <= '0;
         base_q    <= '0;
         rv        <= 1'b0;
         done      <= 1'b0;
         buf_full  <= 1'b0;
         msg_words <= '0;
      end else begin
         done <= 1'b0;
         rv   <= 1'b0;
         if (release_msg) buf_full <= 1'b0;
         case (st)
            C_IDLE: begin
               if (accept) begin
                  st        <= C_SETUP;
                  cnt       <= '0;
                  ic        <= '0;
                  wc        <= '0;
                  base_q    <= base;
                  msg_words <= nwords;
                  buf_full  <= 1'b1;
               end
            end
            C_SETUP: begin
               if (cnt == SW'(CR_SETUP-1)) st <= C_COPY;
               else cnt <= cnt + 1'b1;
            end
            C_COPY: begin
               if (ic < msg_words) begin
                  ic <= ic + 1'b1;
                  rv <= 1'b1;
               end
               if (rv) begin
                  wc <= wc + 1'b1;
                  if (wc == msg_words - 1'b1) begin
                     done <= 1'b1;
                     st   <= C_IDLE;
                  end
               end
            end
            default: st <= C_IDLE;
         endcase
      end
   end

   // R3: completion is a single-cycle pulse
   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/mfp_send.sv
`timescale 1ns/1ps
module mfp_send
   import mfp_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int MAX_WORDS = 16,
   parameter int SD_SETUP  = 5,
   parameter bit MSB_FIRST = 1'b1,
   parameter int LEN_W     = $clog2(MAX_WORDS+1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              buf_full,
   input  logic [LEN_W-1:0]  msg_words,
   input  logic [MAC_W-1:0]  dst,
   input  logic [MAC_W-1:0]  src,
   input  logic [TYPE_W-1:0] etype,
   input  logic              fifo_empty,
   input  logic [WORD_W-1:0] fifo_rdata,
   output logic              fifo_pop,
   output logic              release_msg,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   output logic              tx_last,
   output logic              done,
   output logic              underrun
);
   localparam int LANES = WORD_W / 8;
   localparam int LNW   = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int MAXB  = (LANES*MAX_WORDS > MIN_BODY) ? LANES*MAX_WORDS : MIN_BODY;
   localparam int BCW   = $clog2(MAXB+1);
   localparam int CMAX  = (SD_SETUP > HDR_BYTES) ? SD_SETUP : HDR_BYTES;
   localparam int CW    = $clog2(CMAX+1);

   generate
      if (WORD_W % 8 != 0 || LANES < 2 || (1 << LNW) != LANES) begin : g_bad_width
         $error("mfp_send: WORD_W must be a power-of-two number of bytes, at least two");
      end
      if (SD_SETUP < 1) begin : g_bad_setup
         $error("mfp_send: SD_SETUP must be at least 1");
      end
   endgenerate

   sd_state_t         st;
   logic [CW-1:0]     cnt;
   logic [BCW-1:0]    bc, pay_q, body_q, pay_w, body_w;
   logic [LNW-1:0]    lane;
   logic [HDR_W-1:0]  hdr_q;
   logic [WORD_W-1:0] word_q;
   logic [7:0]        hdr_byte, fifo_b0, q_byte, body_byte;
   logic              accept, in_pay, need_word, last_b;
   logic [BCW:0]      fcnt;

   assign accept    = start && (st == S_IDLE) && buf_full;
   assign pay_w     = BCW'(msg_words) * BCW'(LANES);
   assign body_w    = (pay_w < BCW'(MIN_BODY)) ? BCW'(MIN_BODY) : pay_w;
   assign in_pay    = bc < pay_q;
   assign need_word = (st == S_BODY) && in_pay && (lane == '0);
   assign fifo_pop  = need_word && !fifo_empty;
   assign last_b    = (st == S_BODY) && (bc == body_q - 1'b1);
   assign release_msg = last_b;
   assign hdr_byte  = 8'(hdr_q >> (8*(HDR_BYTES-1-int'(cnt))));

   generate
      if (MSB_FIRST) begin : g_msb
         assign fifo_b0 = fifo_rdata[WORD_W-1 -: 8];
         assign q_byte  = 8'(word_q >> (8*(LANES-1-int'(lane))));
      end else begin : g_lsb
         assign fifo_b0 = fifo_rdata[7:0];
         assign q_byte  = 8'(word_q >> (8*int'(lane)));
      end
   endgenerate

   always_comb begin
      if (!in_pay)          body_byte = 8'h00;
      else if (lane != '0)  body_byte = q_byte;
      else if (fifo_empty)  body_byte = 8'h00;
      else                  body_byte = fifo_b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         bc       <= '0;
         lane     <= '0;
         pay_q    <= '0;
         body_q   <= '0;
         hdr_q    <= '0;
         word_q   <= '0;
         tx_data  <= '0;
         tx_valid <= 1'b0;
         tx_last  <= 1'b0;
         done     <= 1'b0;
         underrun <= 1'b0;
      end else begin
         tx_valid <= 1'b0;
         tx_last  <= 1'b0;
         tx_data  <= '0;
         done     <= 1'b0;
         case (st)
            S_IDLE: begin
               if (accept) begin
                  st     <= S_SETUP;
                  cnt    <= '0;
                  hdr_q  <= {dst, src, etype};
                  pay_q  <= pay_w;
                  body_q <= body_w;
               end
            end
            S_SETUP: begin
               if (cnt == CW'(SD_SETUP-1)) begin
                  st  <= S_HDR;
                  cnt <= '0;
               end else cnt <= cnt + 1'b1;
            end
            S_HDR: begin
               tx_valid <= 1'b1;
               tx_data  <= hdr_byte;
               if (cnt == CW'(HDR_BYTES-1)) begin
                  st   <= S_BODY;
                  bc   <= '0;
                  lane <= '0;
               end else cnt <= cnt + 1'b1;
            end
            S_BODY: begin
               tx_valid <= 1'b1;
               tx_data  <= body_byte;
               bc       <= bc + 1'b1;
               lane     <= lane + 1'b1;
               if (need_word) begin
                  if (fifo_empty) underrun <= 1'b1;
                  else            word_q   <= fifo_rdata;
               end
               if (last_b) begin
                  tx_last <= 1'b1;
                  done    <= 1'b1;
                  st      <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        fcnt <= '0;
      else if (tx_valid) fcnt <= tx_last ? '0 : fcnt + 1'b1;
   end

   // R5: last byte only with valid, and never before the minimum length
   assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);
   assert_min_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_last) |-> (int'(fcnt) >= HDR_BYTES + MIN_BODY - 1));
   // R8: the first FIFO read waits until the header has been streamed
   assert_pop_after_hdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (tx_valid && int'(fcnt) >= HDR_BYTES - 1));
   // R7: completion is a single-cycle pulse
   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: the underrun flag never clears without reset
   assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);
endmodule

// File: rtl/msg_frame_pipe.sv
`timescale 1ns/1ps
module msg_frame_pipe
   import mfp_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int WORD_W    = 32,
   parameter int MAX_WORDS = 16,
   parameter int CR_SETUP  = 8,
   parameter int SD_SETUP  = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           ram_we,
   input  logic [ADDR_W-1:0]              ram_waddr,
   input  logic [WORD_W-1:0]              ram_wdata,
   input  logic                           create_start,
   input  logic [ADDR_W-1:0]              create_base,
   input  logic [$clog2(MAX_WORDS+1)-1:0] create_len,
   input  logic                           send_start,
   input  logic [47:0]                    dst_addr,
   input  logic [47:0]                    src_addr,
   input  logic [15:0]                    eth_type,
   output logic [7:0]                     tx_data,
   output logic                           tx_valid,
   output logic                           tx_last,
   output logic                           create_done,
   output logic                           send_done,
   output logic                           underrun
);
   localparam int LEN_W  = $clog2(MAX_WORDS+1);
   localparam int FDEPTH = 1 << $clog2(MAX_WORDS);

   generate
      if (MAX_WORDS < 1 || MAX_WORDS > (1 << ADDR_W)) begin : g_bad_len
         $error("msg_frame_pipe: MAX_WORDS must fit the variable memory");
      end
   endgenerate

   logic [ADDR_W-1:0] rd_addr;
   logic [WORD_W-1:0] rd_data, f_wdata, f_rdata;
   logic              f_push, f_pop, f_empty, f_full;
   logic              held, release_msg;
   logic [LEN_W-1:0]  held_words;

   mfp_var_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
      .raddr(rd_addr), .rdata(rd_data));

   mfp_create #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS),
                .CR_SETUP(CR_SETUP), .LEN_W(LEN_W)) u_create (
      .clk(clk), .rst_n(rst_n), .start(create_start), .base(create_base),
      .nwords(create_len), .release_msg(release_msg), .ram_raddr(rd_addr),
      .ram_rdata(rd_data), .push(f_push), .push_data(f_wdata),
      .done(create_done), .buf_full(held), .msg_words(held_words));

   mfp_fifo #(.WORD_W(WORD_W), .DEPTH(FDEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(release_msg), .push(f_push),
      .wdata(f_wdata), .pop(f_pop), .rdata(f_rdata), .empty(f_empty),
      .full(f_full));

   mfp_send #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .SD_SETUP(SD_SETUP),
              .MSB_FIRST(MSB_FIRST), .LEN_W(LEN_W)) u_send (
      .clk(clk), .rst_n(rst_n), .start(send_start), .buf_full(held),
      .msg_words(held_words), .dst(dst_addr), .src(src_addr),
      .etype(eth_type), .fifo_empty(f_empty), .fifo_rdata(f_rdata),
      .fifo_pop(f_pop), .release_msg(release_msg), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_last(tx_last), .done(send_done),
      .underrun(underrun));
endmodule

// File: tb/sim_msg_frame_pipe.sv
`timescale 1ns/1ps
module sim_msg_frame_pipe;
   localparam int AW = 6;
   localparam int WW = 32;
   localparam int LW = 5;

   // table: [23:16] expected frame length, [15:8] base, [4:0] words
   localparam logic [23:0] VEC [0:4] = '{24'h3C_00_01, 24'h3C_04_0B,
                                         24'h3E_14_0C, 24'h4E_28_10,
                                         24'h3C_08_04};

   logic clk = 1'b0;
   logic rst_n;
   logic ram_we;
   logic [AW-1:0] ram_waddr, create_base;
   logic [WW-1:0] ram_wdata;
   logic create_start, send_start;
   logic [LW-1:0] create_len;
   logic [47:0] dst_addr, src_addr;
   logic [15:0] eth_type;
   logic [7:0] tx_data, w1_data;
   logic tx_valid, tx_last, create_done, send_done, underrun;
   logic w1_valid, w1_last, w1_cdone, w1_sdone, w1_underrun;

   int cyc = 0;
   int total = 0;
   int bad = 0;
   logic [7:0] cap_d [0:127];
   logic       cap_l [0:127];
   int cap_n, first_t, cd_t, cd_cnt, sd_cnt;
   logic last_sd;

   always #10 clk = ~clk;

   msg_frame_pipe u0 (
      .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
      .ram_wdata(ram_wdata), .create_start(create_start),
      .create_base(create_base), .create_len(create_len),
      .send_start(send_start), .dst_addr(dst_addr), .src_addr(src_addr),
      .eth_type(eth_type), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_last(tx_last), .create_done(create_done), .send_done(send_done),
      .underrun(underrun));

   // slow copy setup: the reader outruns the writer
   msg_frame_pipe #(.CR_SETUP(40)) u1 (
      .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
      .ram_wdata(ram_wdata), .create_start(create_start),
      .create_base(create_base), .create_len(create_len),
      .send_start(send_start), .dst_addr(dst_addr), .src_addr(src_addr),
      .eth_type(eth_type), .tx_data(w1_data), .tx_valid(w1_valid),
      .tx_last(w1_last), .create_done(w1_cdone), .send_done(w1_sdone),
      .underrun(w1_underrun));

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (tx_valid) begin
         if (cap_n == 0) first_t = cyc;
         if (cap_n < 128) begin
            cap_d[cap_n] = tx_data;
            cap_l[cap_n] = tx_last;
         end
         if (tx_last) last_sd = send_done;
         cap_n++;
      end
      if (create_done) begin
         cd_t = cyc;
         cd_cnt++;
      end
      if (send_done) sd_cnt++;
   end

   function automatic logic [31:0] wdat(input int a);
      return {8'(a), 8'(8'hC3 ^ 8'(a)), 8'(a*5), 8'(8'h5A + 8'(a))};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic clear_mon();
      cap_n = 0; first_t = -1; cd_t = -1; cd_cnt = 0; sd_cnt = 0; last_sd = 1'b0;
   endtask

   task automatic pulse_create(input int base, input int n, output int e);
      @(negedge clk);
      create_base = AW'(base); create_len = LW'(n); create_start = 1'b1; e = cyc + 1;
      @(negedge clk);
      create_start = 1'b0;
   endtask

   task automatic pulse_send(output int s);
      @(negedge clk);
      send_start = 1'b1; s = cyc + 1;
      @(negedge clk);
      send_start = 1'b0;
   endtask

   task automatic wait_send();
      for (int i = 0; i < 400 && sd_cnt == 0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      #1;
   endtask

   task automatic check_frame(input int base, input int n, input int exp_n,
                              input logic [111:0] hv);
      int blen, mism, lasts, a, e;
      blen = (4*n < 46) ? 46 : 4*n;
      chk(cap_n == exp_n, "R5 frame length", cap_n, exp_n);
      mism = 0;
      for (int i = 0; i < 14; i++) if (cap_d[i] !== hv[111-8*i -: 8]) mism++;
      chk(mism == 0, "R4 header bytes", mism, 0);
      mism = 0;
      for (int i = 0; i < 4*n; i++) begin
         a = int'(cap_d[14+i]);
         e = int'(wdat(base + i/4) >> (8*(3 - i%4))) & 255;
         if (a != e) mism++;
      end
      chk(mism == 0, "R4 payload order", mism, 0);
      mism = 0;
      for (int i = 4*n; i < blen; i++) if (cap_d[14+i] !== 8'h00) mism++;
      chk(mism == 0, "R5 zero padding", mism, 0);
      lasts = 0;
      for (int i = 0; i < exp_n && i < 128; i++) if (cap_l[i]) lasts++;
      chk(lasts == 1 && cap_l[exp_n-1] === 1'b1, "R5 tx_last placement", lasts, 1);
      chk(last_sd === 1'b1 && sd_cnt == 1, "R7 send_done with last byte", sd_cnt, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
   end

   initial begin
      int e, s, base, n, exp_n;
      logic [111:0] hv;
      rst_n = 1'b0; ram_we = 1'b0; ram_waddr = '0; ram_wdata = '0;
      create_start = 1'b0; create_base = '0; create_len = '0; send_start = 1'b0;
      dst_addr = '0; src_addr = '0; eth_type = '0;
      clear_mon();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: idle outputs after reset
      chk({tx_valid, tx_last, create_done, send_done, underrun} == 5'b0,
          "R1 reset outputs", int'({tx_valid, tx_last, create_done, send_done, underrun}), 0);

      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         ram_we = 1'b1; ram_waddr = AW'(i); ram_wdata = wdat(i);
      end
      @(negedge clk);
      ram_we = 1'b0;

      // R6: send with no held message is ignored
      clear_mon();
      pulse_send(s);
      repeat (40) @(negedge clk); #1;
      chk(cap_n == 0 && sd_cnt == 0, "R6 send without message", cap_n, 0);

      // R2: zero and oversize lengths are refused
      clear_mon();
      pulse_create(0, 0, e);
      repeat (30) @(negedge clk); #1;
      chk(cd_cnt == 0, "R2 zero length ignored", cd_cnt, 0);
      pulse_create(0, 20, e);
      repeat (30) @(negedge clk); #1;
      chk(cd_cnt == 0, "R2 oversize length ignored", cd_cnt, 0);
      pulse_send(s);
      repeat (40) @(negedge clk); #1;
      chk(cap_n == 0, "R6 nothing held after refused creates", cap_n, 0);

      // table walk: create then send one cycle later (R3 R4 R5 R7 R8)
      for (int k = 0; k < 5; k++) begin
         base  = int'(VEC[k][15:8]);
         n     = int'(VEC[k][4:0]);
         exp_n = int'(VEC[k][23:16]);
         hv    = {48'h0A1B2C3D4E50 + 48'(k), 48'hF0E1D2C3B4A0 ^ 48'(k), 16'h88B5 + 16'(k)};
         clear_mon();
         @(negedge clk);
         create_base = AW'(base); create_len = LW'(n); create_start = 1'b1; e = cyc + 1;
         @(negedge clk);
         create_start = 1'b0; send_start = 1'b1; s = cyc + 1;
         dst_addr = hv[111:64]; src_addr = hv[63:16]; eth_type = hv[15:0];
         @(negedge clk);
         send_start = 1'b0;
         wait_send();
         chk(cd_cnt == 1 && cd_t == e + 9 + n, "R3 create_done latency", cd_t - e, 9 + n);
         chk(first_t == s + 6, "R7 first byte latency", first_t - s, 6);
         check_frame(base, n, exp_n, hv);
         chk(underrun == 1'b0, "R8 overlapped run without underrun", int'(underrun), 0);
         if (k == 0) chk(w1_underrun == 1'b1, "R9 slow copy raises underrun", int'(w1_underrun), 1);
      end

      // R2: create while a message is held is ignored
      clear_mon();
      hv = {48'h112233445566, 48'h665544332211, 16'h0800};
      dst_addr = hv[111:64]; src_addr = hv[63:16]; eth_type = hv[15:0];
      pulse_create(2, 2, e);
      repeat (20) @(negedge clk); #1;
      chk(cd_cnt == 1, "R2 first create accepted", cd_cnt, 1);
      pulse_create(30, 3, e);
      repeat (20) @(negedge clk); #1;
      chk(cd_cnt == 1, "R2 create while held ignored", cd_cnt, 1);
      pulse_send(s);
      wait_send();
      check_frame(2, 2, 60, hv);
      // R2: after release a new create is taken
      clear_mon();
      pulse_create(30, 3, e);
      repeat (20) @(negedge clk); #1;
      chk(cd_cnt == 1 && cd_t == e + 12, "R2 create after release", cd_t - e, 12);
      pulse_send(s);
      wait_send();
      check_frame(30, 3, 60, hv);

      chk(w1_underrun == 1'b1, "R9 underrun stays set", int'(w1_underrun), 1);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(w1_underrun == 1'b0 && underrun == 1'b0, "R1 reset clears underrun",
          int'(w1_underrun), 0);

      summary();
      $finish;
   end
endmodule